// File: doc/BRIEF.md
# Converter Result and Status Register

This block sits behind a 24-bit converter core and holds the last conversion result together with a one-byte status word. The core gives it a start strobe and a done strobe. The done strobe carries a signed raw result that is wider than the stored word. The block saturates that result to the 24-bit two's-complement range and keeps a flag for each direction of clipping.

The block also reports whether the measurement engine is busy. It records the rate code that belongs to the held result, or to the most recent calibration. It mirrors a gain-calibration saturation indication from the core.

The ready flag follows a deferred-clear rule:

- A completed read of the result register while the core is idle does not drop ready. The read only arms a clear that takes effect when the next conversion starts.
- A read while a conversion is running clears ready on the following cycle.
- Reading the status byte itself has no side effects.

Top module: `adc_status_reg`

## Requirements
- R1: After reset the result register and every bit of the status byte are 0.
- R2: A done strobe with a raw value inside [-0x800000, 0x7FFFFF] stores that value in the result register on the next cycle, with status bit 3 (over) and bit 2 (under) both 0.
- R3: A raw value above 0x7FFFFF stores 0x7FFFFF and sets status bit 3 to 1 and bit 2 to 0.
- R4: A raw value below -0x800000 stores 0x800000 and sets status bit 2 to 1 and bit 3 to 0.
- R5: Status bit 1 (busy) is 1 from the cycle after a start strobe until the cycle after the matching done strobe, and whenever the calibration-busy input is 1.
- R6: Status bit 0 (ready) is 1 on the cycle after a done strobe.
- R7: If the result is not read before the next start, ready stays 1 through that conversion.
- R8: A read while no conversion is running leaves ready at 1; ready becomes 0 on the cycle after the next start strobe.
- R9: A read while a conversion is running makes ready 0 on the next cycle.
- R10: When done and read occur in the same cycle, done wins: ready is 1 afterwards and any armed clear is discarded.
- R11: Status bits 6:4 show the rate code sampled at the start of the conversion whose result is held. A falling edge of calibration-busy instead loads the current rate code.
- R12: Status bit 7 is the gain-saturation input registered by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Conversion start strobe |
| convDone | input | 1 | Conversion complete strobe; rawResult valid |
| rawResult | input | 28 | Signed unsaturated result |
| rateCode | input | 3 | Currently selected rate code |
| calBusy | input | 1 | Self or system calibration running |
| gainSat | input | 1 | Gain calibration coefficient saturated |
| dataRead | input | 1 | Result register read completed |
| dataReg | output | 24 | Saturated result |
| statusByte | output | 8 | {gainSat, rate[2:0], over, under, busy, ready} |

## Verification
The ready logic has two hidden bits, the running flag and the armed clear. A corrupted armed bit becomes visible only at the next start strobe, when ready drops or wrongly survives one cycle later. A wrong running flag shows on the busy bit at once and changes how a read is treated. The bench therefore compares every port on every cycle against a behavioural model. It pushes reads, starts and done strobes into every ordering, including same-cycle collisions, so that a divergence in a hidden bit appears within one conversion.

// File: rtl/adc_status_pkg.sv
package adc_status_pkg;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic loadResult;
    logic latchPending;
    logic loadCalRate;
  } dpStrobes_t;
endpackage

// File: rtl/adc_status_ctrl.sv
module adc_status_ctrl
  import adc_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       convStart,
  input  logic       convDone,
  input  logic       dataRead,
  input  logic       calBusy,
  input  logic       gainSat,
  output dpStrobes_t strobes,
  output logic       readyFlag,
  output logic       busyFlag,
  output logic       sysOrFlag,
  output logic       converting,
  output logic       armed
);
  logic calBusyQ;

  always_comb begin
    strobes.loadResult   = convDone;
    strobes.latchPending = convStart;
    strobes.loadCalRate  = calBusyQ & ~calBusy;
  end

  assign busyFlag = converting | calBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      converting <= 1'b0;
      calBusyQ   <= 1'b0;
      sysOrFlag  <= 1'b0;
    end else begin
      calBusyQ  <= calBusy;
      sysOrFlag <= gainSat;
      if (convStart)     converting <= 1'b1;
      else if (convDone) converting <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b0;
      armed     <= 1'b0;
    end else if (convDone) begin
      readyFlag <= 1'b1;
      armed     <= 1'b0;
    end else if (convStart && (armed || dataRead)) begin
      readyFlag <= 1'b0;
      armed     <= 1'b0;
    end else if (dataRead && converting) begin
      readyFlag <= 1'b0;
      armed     <= 1'b0;
    end else if (dataRead && readyFlag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_status_dp.sv
module adc_status_dp
  import adc_status_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int RAW_W  = 28
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobes_t               strobes,
  input  logic signed [RAW_W-1:0]  rawResult,
  input  logic [RATE_W-1:0]        rateCode,
  output logic [DATA_W-1:0]        dataReg,
  output logic                     overFlag,
  output logic                     underFlag,
  output logic [RATE_W-1:0]        rateField
);
  localparam logic signed [RAW_W-1:0] MAX_CODE = (RAW_W'(1) <<< (DATA_W-1)) - RAW_W'(1);
  localparam logic signed [RAW_W-1:0] MIN_CODE = -(RAW_W'(1) <<< (DATA_W-1));

  logic [RATE_W-1:0] pendingRate;
  logic              isOver, isUnder;
  logic [DATA_W-1:0] clipped;

  always_comb begin
    isOver  = rawResult > MAX_CODE;
    isUnder = rawResult < MIN_CODE;
    if (isOver)       clipped = MAX_CODE[DATA_W-1:0];
    else if (isUnder) clipped = MIN_CODE[DATA_W-1:0];
    else              clipped = rawResult[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg     <= '0;
      overFlag    <= 1'b0;
      underFlag   <= 1'b0;
      rateField   <= '0;
      pendingRate <= '0;
    end else begin
      if (strobes.latchPending) pendingRate <= rateCode;
      if (strobes.loadResult) begin
        dataReg   <= clipped;
        overFlag  <= isOver;
        underFlag <= isUnder;
        rateField <= pendingRate;
      end else if (strobes.loadCalRate) begin
        rateField <= rateCode;
      end
    end
  end
endmodule

// File: rtl/adc_status_reg.sv
module adc_status_reg
  import adc_status_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int RAW_W  = 28
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    convStart,
  input  logic                    convDone,
  input  logic signed [RAW_W-1:0] rawResult,
  input  logic [RATE_W-1:0]       rateCode,
  input  logic                    calBusy,
  input  logic                    gainSat,
  input  logic                    dataRead,
  output logic [DATA_W-1:0]       dataReg,
  output logic [7:0]              statusByte
);
  dpStrobes_t        strobes;
  logic              readyFlag, busyFlag, sysOrFlag, converting, armed;
  logic              overFlag, underFlag;
  logic [RATE_W-1:0] rateField;

  adc_status_ctrl u_ctrl (
    .clk, .rstN, .convStart, .convDone, .dataRead, .calBusy, .gainSat,
    .strobes, .readyFlag, .busyFlag, .sysOrFlag, .converting, .armed
  );

  adc_status_dp #(.DATA_W(DATA_W), .RAW_W(RAW_W)) u_dp (
    .clk, .rstN, .strobes, .rawResult, .rateCode,
    .dataReg, .overFlag, .underFlag, .rateField
  );

  assign statusByte = {sysOrFlag, rateField, overFlag, underFlag, busyFlag, readyFlag};
endmodule

// File: rtl/adc_status_reg_chk.sv
module adc_status_reg_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              convStart,
  input logic              convDone,
  input logic              dataRead,
  input logic              calBusy,
  input logic              gainSat,
  input logic              converting,
  input logic              armed,
  input logic [DATA_W-1:0] dataReg,
  input logic [7:0]        statusByte
);
  // R6
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> statusByte[0]);

  // R9
  read_in_conv_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && converting && !convDone) |=> !statusByte[0]);

  // R7
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && !armed && !dataRead) |=> statusByte[0]);

  // R3
  over_clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3] |-> (dataReg == {1'b0, {(DATA_W-1){1'b1}}}));

  // R4
  under_clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[2] |-> (dataReg == {1'b1, {(DATA_W-1){1'b0}}}));

  // R2
  range_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[3] && statusByte[2]));

  // R5
  cal_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> statusByte[1]);

  // R12
  sys_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    gainSat |=> statusByte[7]);

  // R8
  armed_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && convStart && !convDone) |=> !statusByte[0]);
endmodule

bind adc_status_reg adc_status_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk, .rstN, .convStart, .convDone, .dataRead, .calBusy, .gainSat,
  .converting, .armed, .dataReg, .statusByte
);

// File: tb/adc_status_reg_bench.sv
`timescale 1ns/100ps
module adc_status_reg_bench;
  logic               clk = 0;
  logic               rstN = 0;
  logic               convStart = 0, convDone = 0, calBusy = 0, gainSat = 0, dataRead = 0;
  logic signed [27:0] rawResult = '0;
  logic [2:0]         rateCode = '0;
  logic [23:0]        dataReg;
  logic [7:0]         statusByte;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_status_reg u_adc_status_reg (
    .clk, .rstN, .convStart, .convDone, .rawResult, .rateCode,
    .calBusy, .gainSat, .dataRead, .dataReg, .statusByte
  );

  // behavioural reference
  bit mConv, mReady, mArm, mOver, mUnder, mSys, mCalPrev;
  int mData, mRate, mPend;

  always @(posedge clk) begin
    longint v;
    if (!rstN) begin
      mConv = 0; mReady = 0; mArm = 0; mOver = 0; mUnder = 0; mSys = 0;
      mCalPrev = 0; mData = 0; mRate = 0; mPend = 0;
    end else begin
      bit wasConv;
      wasConv = mConv;
      if (convDone) begin
        v = rawResult;
        mOver = v > 64'sd8388607;
        mUnder = v < -64'sd8388608;
        mData = mOver ? 'h7FFFFF : mUnder ? 'h800000 : int'(v & 'hFFFFFF);
        mRate = mPend;
        mReady = 1; mArm = 0;
      end else begin
        if (mCalPrev && !calBusy) mRate = rateCode;
        if (convStart && (mArm || dataRead)) begin mReady = 0; mArm = 0; end
        else if (dataRead && wasConv) begin mReady = 0; mArm = 0; end
        else if (dataRead && mReady) mArm = 1;
      end
      if (convStart) mPend = rateCode;
      mConv = convStart ? 1'b1 : (convDone ? 1'b0 : mConv);
      mCalPrev = calBusy;
      mSys = gainSat;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN) begin
      chk("R2 R3 R4 data", int'(dataReg), mData);
      chk("R3 over", int'(statusByte[3]), int'(mOver));
      chk("R4 under", int'(statusByte[2]), int'(mUnder));
      chk("R5 busy", int'(statusByte[1]), int'(mConv | calBusy));
      chk("R6 R7 R8 R9 R10 ready", int'(statusByte[0]), int'(mReady));
      chk("R11 rate", int'(statusByte[6:4]), mRate);
      chk("R12 sysOr", int'(statusByte[7]), int'(mSys));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
    convStart = 0; convDone = 0; dataRead = 0;
  endtask

  task automatic runDirected();
    cyc(3);
    chk("R1 reset data", int'(dataReg), 0);
    chk("R1 reset status", int'(statusByte), 0);
    rstN = 1;
    cyc();
    rateCode = 3; convStart = 1; cyc(); cyc(2);
    rawResult = 28'sd100; convDone = 1; cyc();
    chk("R2 data", int'(dataReg), 100);
    chk("R6 ready", int'(statusByte[0]), 1);
    chk("R11 rate", int'(statusByte[6:4]), 3);
    rateCode = 6; convStart = 1; cyc(); cyc(2);
    chk("R7 ready held", int'(statusByte[0]), 1);
    chk("R11 rate not following", int'(statusByte[6:4]), 3);
    rawResult = 28'sd20000000; convDone = 1; cyc();
    chk("R3 clip", int'(dataReg), 'h7FFFFF);
    dataRead = 1; cyc(); cyc(2);
    chk("R8 idle read keeps ready", int'(statusByte[0]), 1);
    convStart = 1; cyc();
    chk("R8 clear on start", int'(statusByte[0]), 0);
    rawResult = -28'sd20000000; convDone = 1; cyc();
    chk("R4 clip", int'(dataReg), 'h800000);
    convStart = 1; cyc(); cyc();
    chk("R7 ready during conv", int'(statusByte[0]), 1);
    dataRead = 1; cyc();
    chk("R9 read in conv", int'(statusByte[0]), 0);
    rawResult = -28'sd5; convDone = 1; cyc();
    dataRead = 1; cyc();
    convStart = 1; cyc();
    rawResult = 28'sd7; convDone = 1; dataRead = 1; cyc();
    chk("R10 done wins", int'(statusByte[0]), 1);
    convStart = 1; cyc();
    chk("R10 no armed clear", int'(statusByte[0]), 1);
    rawResult = 28'sd1; convDone = 1; cyc();
    rateCode = 5; calBusy = 1; cyc(); cyc(3);
    calBusy = 0; cyc(); cyc();
    chk("R11 cal rate", int'(statusByte[6:4]), 5);
    gainSat = 1; cyc(); cyc();
    chk("R12 sysOr", int'(statusByte[7]), 1);
    gainSat = 0; cyc();
  endtask

  task automatic runRandom();
    bit busyConv = 0;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      rateCode = 3'($urandom);
      if (!busyConv && r < 15) begin convStart = 1; busyConv = 1; end
      else if (busyConv && r < 25) begin
        int k;
        k = $urandom_range(0, 2);
        rawResult = k == 0 ? 28'($signed($urandom_range(0, 16777215)) - 8388608)
                  : k == 1 ? 28'sd8388608 + 28'($urandom_range(0, 1000))
                           : -28'sd8388609 - 28'($urandom_range(0, 1000));
        convDone = 1; busyConv = 0;
        if ($urandom_range(0, 3) == 0) convStart = 1;
        if (convStart) busyConv = 1;
      end
      if ($urandom_range(0, 5) == 0) dataRead = 1;
      if ($urandom_range(0, 40) == 0) calBusy = ~calBusy;
      if ($urandom_range(0, 30) == 0) gainSat = ~gainSat;
      cyc();
    end
  endtask

  initial begin
    fork
      begin runDirected(); runRandom(); cyc(2); end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule